// File: doc/BRIEF.md
# Interrupt Message Queue Writer

This block collects short event reports from a set of channel controllers and a quiesce handler, formats each one as a fixed 64-bit message word, and writes the words one after another into a ring of slots in host memory. The host learns what happened by reading that ring, never by reading a device register: every piece of status leaves the device as a device-initiated write. Channel number 0 is kept for these messages and the quiesce acknowledge. Data channels start at 1, and source i always reports as channel i+1.

Sources are served in round-robin order, one message for each grant. A grant is given only when no message write is in flight and the ring has a free slot. A full ring therefore stalls every source, and no message is ever lost. An interrupt is raised when messages are waiting and the host is not already working through the ring. The host acknowledges by writing its new read pointer. A pointer value beyond the written region is discarded.

Top module: `intr_msg_queue`

## Requirements
- R1: Each message word has opcode in bits [63:56], channel in [55:48], buffer index in [47:32] and byte count in [31:0]. A buffer-release message (source kind 0, opcode 0x01) carries the source's buffer index and byte count. A non-empty message (source kind 1, opcode 0x02) carries zero in both fields.
- R2: Source i reports on channel i+1. The quiesce acknowledge (opcode 0x03) is the only message on channel 0, and its byte count field holds the parameter TBL_LEN.
- R3: Messages are written to slot addresses that increase by one modulo the ring depth, in grant order, starting at slot 0 after reset.
- R4: Requesters are indexed with source i as i and the quiesce handler as NSRC. After a grant to index k, the next grant goes to the first requester found after k, searching cyclically. The search after reset starts at index 0. A grant is a one-cycle pulse on a single grant line, given in the same cycle that mem_wr_valid rises with that requester's message. A grant is never given while a write is pending.
- R5: While mem_wr_valid is high and mem_wr_ready is low, mem_wr_valid, mem_wr_data and mem_wr_addr hold their values.
- R6: When the ring holds as many unacknowledged messages as it has slots, no grant is given and no write is started.
- R7: irq pulses for one cycle after a message write completes into an ring with no interrupt outstanding. No further irq is raised until the host makes an accepted read-pointer write.
- R8: An accepted read-pointer write that leaves unread messages in the ring raises irq in the next cycle.
- R9: A read-pointer write is accepted only if its distance from the current read pointer (modulo 2^(AW+1)) does not exceed the number of written messages. Any other value is ignored: the read pointer, the stall state and the interrupt state stay unchanged.
- R10: After reset, mem_wr_valid, irq and all grants are low and mem_wr_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NSRC | Per-source message request, held until granted |
| src_kind | input | NSRC | Per-source message kind: 0 buffer release, 1 non-empty |
| src_bidx | input | NSRC*16 | Per-source buffer index, source i in bits [16i+15:16i] |
| src_cnt | input | NSRC*32 | Per-source byte count, source i in bits [32i+31:32i] |
| src_gnt | output | NSRC | Per-source grant pulse |
| quiesce_req | input | 1 | Request for a quiesce acknowledge message |
| quiesce_gnt | output | 1 | Grant pulse for the quiesce acknowledge |
| mem_wr_valid | output | 1 | Message write to host memory is pending |
| mem_wr_ready | input | 1 | Host bus accepts the pending write |
| mem_wr_addr | output | AW | Ring slot index of the pending write |
| mem_wr_data | output | 64 | Message word |
| host_rp_we | input | 1 | Host writes its read pointer |
| host_rp | input | AW+1 | New read pointer, with wrap bit |
| irq | output | 1 | Interrupt pulse |

## Verification
The assertions assume that every requester keeps its request and payload steady until it sees its grant, and drops the request in that grant cycle. The bench does this at each falling edge: it clears the request of a source in the same cycle its grant is seen, and it changes payloads only while a source is idle. Bus readiness and host acknowledges are drawn at random. The random acknowledges include out-of-range pointers, built as distances beyond the written count, so the ignore path is exercised. A directed phase fills the ring with acknowledges stopped, offers a bad pointer while the ring is full, and then releases the ring.

// File: rtl/hmq_pkg.sv
package hmq_pkg;
  localparam int MSG_W = 64;

  typedef enum logic [7:0] {
    OPC_RELEASE  = 8'h01,
    OPC_NONEMPTY = 8'h02,
    OPC_QACK     = 8'h03
  } opc_e;

  typedef struct packed {
    logic [7:0]  opc;
    logic [7:0]  chan;
    logic [15:0] bidx;
    logic [31:0] cnt;
  } msg_t;

  function automatic msg_t fmt_msg(opc_e o, logic [7:0] ch, logic [15:0] b, logic [31:0] c);
    msg_t m;
    m.opc  = o;
    m.chan = ch;
    m.bidx = b;
    m.cnt  = c;
    return m;
  endfunction
endpackage

// File: rtl/hmq_rr_arb.sv
module hmq_rr_arb #(
  parameter int N = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          en,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gidx,
  output logic          any
);
  logic [IW-1:0] last;

  // search cyclically starting just after the last winner
  always_comb begin
    any  = 1'b0;
    gidx = '0;
    for (int off = 1; off <= N; off++) begin
      int k;
      k = int'(last) + off;
      if (k >= N) k = k - N;
      if (!any && req[k]) begin
        any  = 1'b1;
        gidx = IW'(k);
      end
    end
    gnt = '0;
    if (en && any) gnt[gidx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) last <= IW'(N - 1);
    else if (en && any) last <= gidx;
  end

  AST_WINNER_REQUESTS: assert property (@(posedge clk) disable iff (rst)
    (|gnt) |-> (gnt & req) == gnt) else $error("grant without request"); // R4
endmodule

// File: rtl/hmq_ring_ctl.sv
module hmq_ring_ctl #(
  parameter int AW = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        commit,
  input  logic        host_we,
  input  logic [AW:0] host_rp,
  output logic [AW:0] wp,
  output logic        room,
  output logic        irq
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH = PW'(1) << AW;

  logic [PW-1:0] rp, used, adv, wp_n, rp_n;
  logic          pend, ack_ok, pend_tmp, irq_n;

  always_comb begin
    used     = wp - rp;
    adv      = host_rp - rp;
    ack_ok   = host_we && (adv <= used);
    wp_n     = wp + PW'(commit);
    rp_n     = ack_ok ? host_rp : rp;
    pend_tmp = pend && !ack_ok;
    // interrupt whenever messages wait and host is not already servicing
    irq_n    = !pend_tmp && (wp_n != rp_n);
    room     = used < DEPTH;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      rp   <= '0;
      pend <= 1'b0;
      irq  <= 1'b0;
    end else begin
      wp   <= wp_n;
      rp   <= rp_n;
      pend <= pend_tmp | irq_n;
      irq  <= irq_n;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (wp - rp) <= DEPTH) else $error("ring overflow"); // R6
  AST_BAD_ACK_IGNORED: assert property (@(posedge clk) disable iff (rst)
    host_we && ((host_rp - rp) > (wp - rp)) |=> rp == $past(rp)) else $error("bad pointer taken"); // R9
  AST_IRQ_ONCE: assert property (@(posedge clk) disable iff (rst)
    irq && !host_we |=> !irq) else $error("repeated irq"); // R7
endmodule

// File: rtl/intr_msg_queue.sv
module intr_msg_queue #(
  parameter int          NSRC    = 4,
  parameter int          AW      = 3,
  parameter logic [31:0] TBL_LEN = 32'h0000_0140
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSRC-1:0]    src_req,
  input  logic [NSRC-1:0]    src_kind,
  input  logic [NSRC*16-1:0] src_bidx,
  input  logic [NSRC*32-1:0] src_cnt,
  output logic [NSRC-1:0]    src_gnt,
  input  logic               quiesce_req,
  output logic               quiesce_gnt,
  output logic               mem_wr_valid,
  input  logic               mem_wr_ready,
  output logic [AW-1:0]      mem_wr_addr,
  output logic [63:0]        mem_wr_data,
  input  logic               host_rp_we,
  input  logic [AW:0]        host_rp,
  output logic               irq
);
  import hmq_pkg::*;

  localparam int NS = NSRC + 1;
  localparam int IW = (NS > 1) ? $clog2(NS) : 1;

  msg_t          cand [NS];
  logic [NS-1:0] req_all, gnt_c;
  logic [IW-1:0] gidx;
  logic          any, arb_en, commit, room;
  logic [AW:0]   wp;

  assign req_all = {quiesce_req, src_req};
  assign commit  = mem_wr_valid && mem_wr_ready;
  assign arb_en  = !mem_wr_valid && room;

  // message formatting per requester
  for (genvar i = 0; i < NSRC; i++) begin : g_fmt
    always_comb begin
      if (src_kind[i])
        cand[i] = fmt_msg(OPC_NONEMPTY, 8'(i + 1), 16'h0, 32'h0);
      else
        cand[i] = fmt_msg(OPC_RELEASE, 8'(i + 1), src_bidx[i*16 +: 16], src_cnt[i*32 +: 32]);
    end
  end
  assign cand[NSRC] = fmt_msg(OPC_QACK, 8'h00, 16'h0, TBL_LEN);

  hmq_rr_arb #(.N(NS)) arb_i (
    .clk  (clk),
    .rst  (rst),
    .req  (req_all),
    .en   (arb_en),
    .gnt  (gnt_c),
    .gidx (gidx),
    .any  (any)
  );

  hmq_ring_ctl #(.AW(AW)) ctl_i (
    .clk     (clk),
    .rst     (rst),
    .commit  (commit),
    .host_we (host_rp_we),
    .host_rp (host_rp),
    .wp      (wp),
    .room    (room),
    .irq     (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_wr_valid <= 1'b0;
      mem_wr_addr  <= '0;
      mem_wr_data  <= '0;
      src_gnt      <= '0;
      quiesce_gnt  <= 1'b0;
    end else begin
      src_gnt     <= gnt_c[NSRC-1:0];
      quiesce_gnt <= gnt_c[NSRC];
      if (arb_en && any) begin
        mem_wr_valid <= 1'b1;
        mem_wr_data  <= cand[gidx];
        mem_wr_addr  <= wp[AW-1:0];
      end else if (commit) begin
        mem_wr_valid <= 1'b0;
      end
    end
  end

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_data) && $stable(mem_wr_addr))
    else $error("write changed while stalled"); // R5
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({quiesce_gnt, src_gnt})) else $error("multiple grants"); // R4
  AST_GNT_STARTS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (|{quiesce_gnt, src_gnt}) |-> $rose(mem_wr_valid)) else $error("grant without new write"); // R4
  AST_CH0_ONLY_QACK: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid && mem_wr_data[55:48] == 8'h00 |-> mem_wr_data[63:56] == 8'h03 && mem_wr_data[31:0] == TBL_LEN)
    else $error("channel 0 misuse"); // R2
endmodule

// File: tb/intr_msg_queue_tb.sv
module intr_msg_queue_tb_top;
  localparam int NSRC = 4;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;
  localparam int PW = AW + 1;
  localparam int NS = NSRC + 1;
  localparam logic [31:0] TBL = 32'h0000_0140;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NSRC-1:0]    src_req = '0, src_kind = '0, src_gnt;
  logic [NSRC*16-1:0] src_bidx = '0;
  logic [NSRC*32-1:0] src_cnt = '0;
  logic               quiesce_req = 1'b0, quiesce_gnt;
  logic               mem_wr_valid, mem_wr_ready = 1'b0;
  logic [AW-1:0]      mem_wr_addr;
  logic [63:0]        mem_wr_data;
  logic               host_rp_we = 1'b0;
  logic [AW:0]        host_rp = '0;
  logic               irq;

  always #10 clk = ~clk;

  intr_msg_queue #(.NSRC(NSRC), .AW(AW), .TBL_LEN(TBL)) dut_i (
    .clk(clk), .rst(rst), .src_req(src_req), .src_kind(src_kind), .src_bidx(src_bidx),
    .src_cnt(src_cnt), .src_gnt(src_gnt), .quiesce_req(quiesce_req), .quiesce_gnt(quiesce_gnt),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .host_rp_we(host_rp_we), .host_rp(host_rp), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  logic [PW-1:0] ewp = '0, erp = '0, c_ackval = '0;
  bit  epend = 0, c_commit = 0, c_ackok = 0, c_arb = 0, prev_valid = 0, prev_ready = 0;
  logic [NS-1:0] c_reqmask = '0;
  logic [63:0] prev_data = '0;
  int last = NS - 1;
  int p_req, p_ready, p_ack, p_bad;

  task automatic chk(bit ok, string rq, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic int rr_pick(int lst, logic [NS-1:0] m);
    for (int off = 1; off <= NS; off++) begin
      int k;
      k = (lst + off) % NS;
      if (m[k]) return k;
    end
    return -1;
  endfunction

  function automatic logic [63:0] exp_msg(int idx);
    if (idx == NSRC) return {8'h03, 8'h00, 16'h0000, TBL};
    if (src_kind[idx]) return {8'h02, 8'(idx + 1), 16'h0000, 32'h0};
    return {8'h01, 8'(idx + 1), src_bidx[idx*16 +: 16], src_cnt[idx*32 +: 32]};
  endfunction

  task automatic step();
    bit pt, eirq;
    int g;
    logic [NS-1:0] gexp;
    logic [PW-1:0] used, diff;
    @(negedge clk);
    if (c_commit) ewp = ewp + 1'b1;
    if (c_ackok) erp = c_ackval;
    pt   = c_ackok ? 1'b0 : epend;
    eirq = !pt && (ewp != erp);
    epend = pt | eirq;
    chk(irq === eirq, c_ackok ? "R8 irq after ack" : "R7 irq", 64'(irq), 64'(eirq));
    if (prev_valid && !prev_ready)
      chk(mem_wr_valid && mem_wr_data == prev_data, "R5 hold", mem_wr_data, prev_data);
    g = c_arb ? rr_pick(last, c_reqmask) : -1;
    gexp = '0;
    if (g >= 0) gexp[g] = 1'b1;
    chk({quiesce_gnt, src_gnt} === gexp, "R4 grant", 64'({quiesce_gnt, src_gnt}), 64'(gexp));
    if (g >= 0) begin
      logic [63:0] m;
      m = exp_msg(g);
      chk(mem_wr_data[63:48] == m[63:48], "R2 opcode/channel", mem_wr_data, m);
      chk(mem_wr_data == m, "R1 message word", mem_wr_data, m);
      chk(mem_wr_addr == ewp[AW-1:0], "R3 slot", 64'(mem_wr_addr), 64'(ewp[AW-1:0]));
      last = g;
      if (g == NSRC) quiesce_req = 1'b0;
      else src_req[g] = 1'b0;
    end
    // new stimulus
    for (int i = 0; i < NSRC; i++) begin
      if (!src_req[i] && ($urandom % 100) < p_req) begin
        src_kind[i] = 1'($urandom);
        src_bidx[i*16 +: 16] = 16'($urandom);
        src_cnt[i*32 +: 32] = $urandom;
        src_req[i] = 1'b1;
      end
    end
    if (!quiesce_req && ($urandom % 100) < p_req / 4) quiesce_req = 1'b1;
    mem_wr_ready = ($urandom % 100) < p_ready;
    used = ewp - erp;
    host_rp_we = 1'b0;
    diff = '0;
    if (($urandom % 100) < p_ack) begin
      if (($urandom % 100) < p_bad)
        diff = PW'(int'(used) + 1 + int'($urandom % (2 * DEPTH - int'(used) - 1)));
      else
        diff = PW'($urandom % (int'(used) + 1));
      host_rp = erp + diff;
      host_rp_we = 1'b1;
    end
    c_ackok   = host_rp_we && (diff <= used);
    c_ackval  = host_rp;
    c_commit  = mem_wr_valid && mem_wr_ready;
    c_arb     = !mem_wr_valid && (int'(used) < DEPTH);
    c_reqmask = {quiesce_req, src_req};
    prev_valid = mem_wr_valid;
    prev_ready = mem_wr_ready;
    prev_data  = mem_wr_data;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL R4 watchdog expired act=0 exp=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(mem_wr_valid === 1'b0, "R10 valid", 64'(mem_wr_valid), 0);
    chk(irq === 1'b0, "R10 irq", 64'(irq), 0);
    chk({quiesce_gnt, src_gnt} === '0, "R10 grants", 64'({quiesce_gnt, src_gnt}), 0);
    chk(mem_wr_addr === '0, "R10 addr", 64'(mem_wr_addr), 0);
    rst = 1'b0;

    p_req = 30; p_ready = 70; p_ack = 20; p_bad = 20;
    repeat (3000) step();

    // directed: fill the ring with the host silent
    p_ack = 0; p_req = 100; p_ready = 100;
    repeat (4 * DEPTH + 4) step();
    chk(int'(PW'(ewp - erp)) == DEPTH && !mem_wr_valid, "R6 full stall",
        64'(PW'(ewp - erp)), 64'(DEPTH));
    // out-of-range pointer while full
    p_ack = 100; p_bad = 100;
    step();
    p_ack = 0;
    repeat (6) step();
    chk(!mem_wr_valid && int'(PW'(ewp - erp)) == DEPTH, "R9 bad pointer ignored",
        64'(mem_wr_valid), 0);
    chk(irq === 1'b0, "R9 no irq", 64'(irq), 0);
    // release the ring
    p_ack = 100; p_bad = 0;
    repeat (4) step();

    p_req = 50; p_ready = 50; p_ack = 15; p_bad = 30;
    repeat (3000) step();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule